// File: doc/BRIEF.md
# Pseudo-Channel DRAM Command Scheduler

This block issues DRAM commands for one stacked-memory channel that is divided into two pseudo-channels. Each pseudo-channel takes read and write requests through its own valid/ready queue and keeps its own open-row and timing state for every bank. Only one command/address bus exists, so the two pseudo-channels contend for it cycle by cycle. The scheduler turns each request into the activate, precharge and column commands it needs. An open row is reused when a request hits it.

A refresh interval counter periodically raises a refresh request. New activates and column commands then wait, every open bank in both pseudo-channels is precharged, and a single all-bank refresh goes out. After it the bus stays silent for the refresh recovery time. A thermal throttle input spaces column commands at a fixed minimum distance while it is high. Requests are served strictly in order within each pseudo-channel. Every column command moves one four-beat burst, which is 32 bytes on a 64-bit pseudo-channel.

Top module: `pc_cmd_sched`

## Requirements
- R1: During and directly after reset `cmd_valid` is 0 and both bits of `req_ready` are 1.
- R2: At most one command is presented per cycle. The command is encoded on `cmd_kind` as activate=1, read=2, write=3, precharge=4 and refresh=5. When both pseudo-channels have a legal command in the same cycle, the one not granted most recently wins, and pseudo-channel 0 is preferred after reset.
- R3: A read or write to a bank comes no earlier than TRCD cycles after that bank's activate.
- R4: A precharge to a bank comes no earlier than TRAS cycles after that bank's activate.
- R5: An activate goes only to a closed bank and comes no earlier than TRP cycles after that bank's precharge.
- R6: A request whose row is already open in its bank gets no activate. A row miss gets a precharge, then an activate of the new row, then the column command. With no contention, each of these issues in the first cycle its timing limit allows.
- R7: Within each pseudo-channel, column commands follow request acceptance order. Each one carries the request's bank and column on `cmd_bank`/`cmd_col`, and a read (`req_write`=0) gives code 2 while a write gives code 3.
- R8: A refresh (code 5) is issued once per TREFI-cycle interval. It goes out only when all banks of both pseudo-channels are closed and at least TRP cycles past their last precharge.
- R9: No command of any kind is presented in the TRFC-1 cycles that follow a refresh.
- R10: While `throttle` is 1, consecutive column commands on the shared bus are at least THR_GAP cycles apart. They are exactly THR_GAP cycles apart when the next one is otherwise ready. Activates and precharges are not affected.
- R11: `req_ready[p]` is 0 while pseudo-channel p holds QDEPTH queued requests. Every accepted request is eventually served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| throttle | input | 1 | Thermal throttle, limits column command rate |
| req_valid | input | 2 | Request valid, one bit per pseudo-channel |
| req_ready | output | 2 | Request ready, one bit per pseudo-channel |
| req_write | input | 2 | 1 = write, 0 = read, per pseudo-channel |
| req_bank | input | 2*BANKW | Bank field, pseudo-channel p at [p*BANKW +: BANKW] |
| req_row | input | 2*ROWW | Row field, pseudo-channel p at [p*ROWW +: ROWW] |
| req_col | input | 2*COLW | Column field, pseudo-channel p at [p*COLW +: COLW] |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_kind | output | 3 | Command code (see R2) |
| cmd_pc | output | 1 | Pseudo-channel of the command |
| cmd_bank | output | BANKW | Target bank |
| cmd_row | output | ROWW | Row for activates |
| cmd_col | output | COLW | Column for reads and writes |

## Verification
The collision that matters is two pseudo-channels holding a legal command in the same cycle. The bench provokes it by accepting identical activate-then-hit request pairs on both queues at the same edges, so the activates and then the column commands meet on the bus. The bench predicts the full six-command order and the cycle offset of each command from TRCD and the round-robin rule, and it compares each one. Random traffic with throttle toggling then lets refresh, throttling and contention overlap. A bench-side bank model judges every command against the timing limits.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_kind_e;
endpackage

// File: rtl/pcs_fifo.sv
module pcs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
        end
        if (pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        end
        if (push && !pop) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (pop && !push) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/pcs_chan.sv
module pcs_chan
    import pcs_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BANKW  = 2,
    parameter int ROWW   = 8,
    parameter int COLW   = 6,
    parameter int TRCD   = 3,
    parameter int TRAS   = 8,
    parameter int TRP    = 3,
    parameter int QDEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_write,
    input  logic [BANKW-1:0] in_bank,
    input  logic [ROWW-1:0]  in_row,
    input  logic [COLW-1:0]  in_col,
    input  logic             hold,
    input  logic             col_ok,
    output logic             want,
    output cmd_kind_e        want_kind,
    output logic [BANKW-1:0] want_bank,
    output logic [ROWW-1:0]  want_row,
    output logic [COLW-1:0]  want_col,
    input  logic             grant,
    output logic             all_idle
);
    localparam int REQW = 1 + BANKW + ROWW + COLW;
    localparam int TMAX = (TRAS > TRCD) ? ((TRAS > TRP) ? TRAS : TRP)
                                        : ((TRCD > TRP) ? TRCD : TRP);
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        logic [NBANK-1:0]           open;
        logic [NBANK-1:0][ROWW-1:0] row;
        logic [NBANK-1:0][TW-1:0]   rcd;
        logic [NBANK-1:0][TW-1:0]   ras;
        logic [NBANK-1:0][TW-1:0]   rp;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [REQW-1:0]  head;
    logic             q_empty, q_full, q_push, q_pop;
    logic             h_write;
    logic [BANKW-1:0] h_bank;
    logic [ROWW-1:0]  h_row;
    logic [COLW-1:0]  h_col;
    logic             is_col;

    assign {h_write, h_bank, h_row, h_col} = head;
    assign in_ready = !q_full;
    assign q_push   = in_valid && !q_full;
    assign is_col   = (want_kind == CMD_RD) || (want_kind == CMD_WR);
    assign q_pop    = grant && is_col;

    pcs_fifo #(.W(REQW), .DEPTH(QDEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   ({in_write, in_bank, in_row, in_col}),
        .pop   (q_pop),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    // command selection for this pseudo-channel
    always_comb begin
        want      = 1'b0;
        want_kind = CMD_NOP;
        want_bank = h_bank;
        want_row  = h_row;
        want_col  = h_col;
        if (hold) begin
            // refresh pending: close banks, lowest index first
            for (int b = NBANK - 1; b >= 0; b--) begin
                if (st_q.open[b] && (st_q.ras[b] == '0)) begin
                    want      = 1'b1;
                    want_kind = CMD_PRE;
                    want_bank = BANKW'(b);
                end
            end
        end else if (!q_empty) begin
            if (st_q.open[h_bank]) begin
                if (st_q.row[h_bank] == h_row) begin
                    if ((st_q.rcd[h_bank] == '0) && col_ok) begin
                        want      = 1'b1;
                        want_kind = h_write ? CMD_WR : CMD_RD;
                    end
                end else if (st_q.ras[h_bank] == '0) begin
                    want      = 1'b1;
                    want_kind = CMD_PRE;
                end
            end else if (st_q.rp[h_bank] == '0) begin
                want      = 1'b1;
                want_kind = CMD_ACT;
            end
        end
    end

    // bank state update
    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBANK; b++) begin
            if (st_q.rcd[b] != '0) st_d.rcd[b] = st_q.rcd[b] - TW'(1);
            if (st_q.ras[b] != '0) st_d.ras[b] = st_q.ras[b] - TW'(1);
            if (st_q.rp[b]  != '0) st_d.rp[b]  = st_q.rp[b]  - TW'(1);
        end
        if (grant) begin
            if (want_kind == CMD_ACT) begin
                st_d.open[want_bank] = 1'b1;
                st_d.row[want_bank]  = want_row;
                st_d.rcd[want_bank]  = TW'(TRCD - 1);
                st_d.ras[want_bank]  = TW'(TRAS - 1);
            end else if (want_kind == CMD_PRE) begin
                st_d.open[want_bank] = 1'b0;
                st_d.rp[want_bank]   = TW'(TRP - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign all_idle = (st_q.open == '0) && (st_q.rp == '0);

    // R3
    rcd_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && is_col) |-> (st_q.open[want_bank] && (st_q.rcd[want_bank] == '0)
                               && (st_q.row[want_bank] == want_row)));
    // R4
    ras_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && want_kind == CMD_PRE) |-> (st_q.open[want_bank] && (st_q.ras[want_bank] == '0)));
    // R5
    rp_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && want_kind == CMD_ACT) |-> (!st_q.open[want_bank] && (st_q.rp[want_bank] == '0)));
    // R6
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && want_kind == CMD_ACT) |=> st_q.open[$past(want_bank)]);
endmodule

// File: rtl/pc_cmd_sched.sv
module pc_cmd_sched
    import pcs_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int BANKW   = (NBANK > 1) ? $clog2(NBANK) : 1,
    parameter int ROWW    = 8,
    parameter int COLW    = 6,
    parameter int TRCD    = 3,
    parameter int TRAS    = 8,
    parameter int TRP     = 3,
    parameter int TRFC    = 20,
    parameter int TREFI   = 300,
    parameter int THR_GAP = 4,
    parameter int QDEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              throttle,
    input  logic [1:0]        req_valid,
    output logic [1:0]        req_ready,
    input  logic [1:0]        req_write,
    input  logic [2*BANKW-1:0] req_bank,
    input  logic [2*ROWW-1:0] req_row,
    input  logic [2*COLW-1:0] req_col,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic              cmd_pc,
    output logic [BANKW-1:0]  cmd_bank,
    output logic [ROWW-1:0]   cmd_row,
    output logic [COLW-1:0]   cmd_col
);
    localparam int NPC = 2;
    localparam int IW  = $clog2(TREFI);
    localparam int FW  = $clog2(TRFC + 1);
    localparam int GW  = $clog2(THR_GAP + 1);

    typedef struct packed {
        logic [IW-1:0] refi;
        logic          ref_pend;
        logic [FW-1:0] rfc;
        logic [GW-1:0] gap;
        logic          rr;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [NPC-1:0]   want, grant, idle;
    cmd_kind_e        want_kind [NPC];
    logic [BANKW-1:0] want_bank [NPC];
    logic [ROWW-1:0]  want_row  [NPC];
    logic [COLW-1:0]  want_col  [NPC];
    logic             hold, col_ok, ref_fire, sel, col_issue;

    assign hold   = st_q.ref_pend || (st_q.rfc != '0);
    assign col_ok = !throttle || (st_q.gap >= GW'(THR_GAP));

    for (genvar p = 0; p < NPC; p++) begin : g_pc
        pcs_chan #(
            .NBANK(NBANK), .BANKW(BANKW), .ROWW(ROWW), .COLW(COLW),
            .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .QDEPTH(QDEPTH)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (req_valid[p]),
            .in_ready  (req_ready[p]),
            .in_write  (req_write[p]),
            .in_bank   (req_bank[p*BANKW +: BANKW]),
            .in_row    (req_row[p*ROWW +: ROWW]),
            .in_col    (req_col[p*COLW +: COLW]),
            .hold      (hold),
            .col_ok    (col_ok),
            .want      (want[p]),
            .want_kind (want_kind[p]),
            .want_bank (want_bank[p]),
            .want_row  (want_row[p]),
            .want_col  (want_col[p]),
            .grant     (grant[p]),
            .all_idle  (idle[p])
        );
    end

    // bus arbitration: refresh first, then round-robin between pseudo-channels
    always_comb begin
        ref_fire = st_q.ref_pend && (st_q.rfc == '0) && (&idle);
        grant    = '0;
        sel      = (want == 2'b11) ? st_q.rr : want[1];
        if (!ref_fire) begin
            grant[sel] = want[sel];
        end
        col_issue = (|grant) && ((want_kind[sel] == CMD_RD) || (want_kind[sel] == CMD_WR));
    end

    always_comb begin
        cmd_valid = ref_fire || (|grant);
        cmd_kind  = ref_fire ? CMD_REF : ((|grant) ? want_kind[sel] : CMD_NOP);
        cmd_pc    = ref_fire ? 1'b0 : sel;
        cmd_bank  = ref_fire ? '0 : want_bank[sel];
        cmd_row   = ref_fire ? '0 : want_row[sel];
        cmd_col   = ref_fire ? '0 : want_col[sel];
    end

    always_comb begin
        st_d = st_q;
        if (st_q.rfc != '0) st_d.rfc = st_q.rfc - FW'(1);
        if (st_q.gap < GW'(THR_GAP)) st_d.gap = st_q.gap + GW'(1);
        if (col_issue) st_d.gap = GW'(1);
        if (|grant) st_d.rr = ~sel;
        if (ref_fire) begin
            st_d.ref_pend = 1'b0;
            st_d.rfc      = FW'(TRFC - 1);
        end
        if (st_q.refi == IW'(TREFI - 1)) begin
            st_d.refi     = '0;
            st_d.ref_pend = 1'b1;
        end else begin
            st_d.refi = st_q.refi + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.gap <= GW'(THR_GAP);
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, ref_fire}));
    // R2
    rr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((want == 2'b11) && !ref_fire) ##1 ((want == 2'b11) && !ref_fire) |-> (grant != $past(grant)));
    // R8
    ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_REF) |-> (&idle));
    // R9
    rfc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rfc != '0) |-> !cmd_valid);
    // R10
    if (THR_GAP > 1) begin : g_thr_chk
        throttle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            col_issue ##1 throttle |-> !col_issue);
    end
endmodule

// File: tb/test_pc_cmd_sched.sv
module test_pc_cmd_sched;
    localparam int NB = 4, BW = 2, RW = 8, CW = 6;
    localparam int TRCD = 3, TRAS = 8, TRP = 3, TRFC = 20, TREFI = 300, GAP = 4, QD = 2;
    localparam int K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4, K_REF = 5;
    localparam int QN = 4096, LN = 8192;

    logic clk = 0, rst_n = 0, throttle = 0;
    logic [1:0] req_valid = 0, req_ready, req_write = 0;
    logic [2*BW-1:0] req_bank = 0;
    logic [2*RW-1:0] req_row = 0;
    logic [2*CW-1:0] req_col = 0;
    logic cmd_valid, cmd_pc;
    logic [2:0] cmd_kind;
    logic [BW-1:0] cmd_bank;
    logic [RW-1:0] cmd_row;
    logic [CW-1:0] cmd_col;

    always #5 clk = ~clk;

    pc_cmd_sched #(.NBANK(NB), .BANKW(BW), .ROWW(RW), .COLW(CW), .TRCD(TRCD), .TRAS(TRAS),
                   .TRP(TRP), .TRFC(TRFC), .TREFI(TREFI), .THR_GAP(GAP), .QDEPTH(QD))
    i_pc_cmd_sched (.*);

    int n_cmp = 0, n_bad = 0, cyc = 0, n_ref = 0, n_log = 0;
    bit finished = 0;
    int last_ref = -100000, last_col = -100000;
    bit m_open [2][NB];
    int m_row [2][NB], m_tact [2][NB], m_tpre [2][NB];
    int q_w [2][QN], q_b [2][QN], q_r [2][QN], q_c [2][QN];
    int q_h [2], q_t [2];
    int l_k [LN], l_p [LN], l_b [LN], l_r [LN], l_t [LN];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        for (int p = 0; p < 2; p++) begin
            q_h[p] = 0; q_t[p] = 0;
            for (int b = 0; b < NB; b++) begin
                m_open[p][b] = 0; m_row[p][b] = 0; m_tact[p][b] = -100000; m_tpre[p][b] = -100000;
            end
        end
    end

    // monitor and bank model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (req_valid[p] && req_ready[p]) begin
                    q_w[p][q_t[p] % QN] = req_write[p];
                    q_b[p][q_t[p] % QN] = req_bank[p*BW +: BW];
                    q_r[p][q_t[p] % QN] = req_row[p*RW +: RW];
                    q_c[p][q_t[p] % QN] = req_col[p*CW +: CW];
                    q_t[p]++;
                end
            end
            if (cmd_valid) begin
                int p, b, t, k;
                p = cmd_pc; b = cmd_bank; t = cyc; k = cmd_kind;
                if (n_log < LN) begin
                    l_k[n_log] = k; l_p[n_log] = p; l_b[n_log] = b; l_r[n_log] = cmd_row; l_t[n_log] = t;
                    n_log++;
                end
                chk(t - last_ref >= TRFC, "R9 gap after refresh", t - last_ref, TRFC);
                case (k)
                    K_ACT: begin
                        chk(!m_open[p][b], "R5 activate to closed bank", m_open[p][b], 0);
                        chk(t - m_tpre[p][b] >= TRP, "R5 precharge to activate", t - m_tpre[p][b], TRP);
                        m_open[p][b] = 1; m_row[p][b] = cmd_row; m_tact[p][b] = t;
                    end
                    K_RD, K_WR: begin
                        int i;
                        i = q_h[p] % QN;
                        chk(q_h[p] != q_t[p], "R7 column with pending request", q_t[p] - q_h[p], 1);
                        chk(t - m_tact[p][b] >= TRCD, "R3 activate to column", t - m_tact[p][b], TRCD);
                        chk(b == q_b[p][i], "R7 column bank", b, q_b[p][i]);
                        chk(cmd_col == q_c[p][i], "R7 column field", cmd_col, q_c[p][i]);
                        chk(k == (q_w[p][i] ? K_WR : K_RD), "R7 read/write code", k, q_w[p][i] ? K_WR : K_RD);
                        chk(m_open[p][b] && m_row[p][b] == q_r[p][i], "R6 open row matches request",
                            m_row[p][b], q_r[p][i]);
                        if (throttle) chk(t - last_col >= GAP, "R10 throttled column spacing", t - last_col, GAP);
                        last_col = t;
                        q_h[p]++;
                    end
                    K_PRE: begin
                        chk(m_open[p][b], "R4 precharge to open bank", m_open[p][b], 1);
                        chk(t - m_tact[p][b] >= TRAS, "R4 activate to precharge", t - m_tact[p][b], TRAS);
                        m_open[p][b] = 0; m_tpre[p][b] = t;
                    end
                    K_REF: begin
                        for (int pp = 0; pp < 2; pp++)
                            for (int bb = 0; bb < NB; bb++) begin
                                chk(!m_open[pp][bb], "R8 bank closed at refresh", m_open[pp][bb], 0);
                                chk(t - m_tpre[pp][bb] >= TRP, "R8 precharge settled at refresh",
                                    t - m_tpre[pp][bb], TRP);
                            end
                        last_ref = t; n_ref++;
                    end
                    default: chk(0, "R2 legal command code", k, 1);
                endcase
            end
        end
    end

    task automatic send(input int p, input int w, input int b, input int r, input int c);
        req_write[p] = w[0];
        req_bank[p*BW +: BW] = BW'(b);
        req_row[p*RW +: RW] = RW'(r);
        req_col[p*CW +: CW] = CW'(c);
        req_valid[p] = 1;
        do @(negedge clk); while (!req_ready[p]);
        @(posedge clk); #1;
        req_valid[p] = 0;
    endtask

    task automatic wait_after_ref();
        int r0;
        r0 = n_ref;
        while (n_ref == r0) @(negedge clk);
        repeat (TRFC + 2) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic wait_log(input int n);
        while (n_log < n) @(negedge clk);
    endtask

    task automatic expect_cmd(input int idx, input int t0, input int k, input int p, input int off, input string tag);
        chk(l_k[idx] == k, {tag, " kind"}, l_k[idx], k);
        chk(l_p[idx] == p, {tag, " pseudo-channel"}, l_p[idx], p);
        chk(l_t[idx] - t0 == off, {tag, " cycle offset"}, l_t[idx] - t0, off);
    endtask

    task automatic rand_traffic(input int p, input int n, input int seed);
        int unsigned s;
        s = seed;
        for (int i = 0; i < n; i++) begin
            s = s * 1103515245 + 12345;
            repeat (int'(s >> 28) % 4) begin @(posedge clk); #1; end
            send(p, int'((s >> 20) & 1), int'((s >> 8) % NB), int'((s >> 12) % 3), int'((s >> 16) % 64));
        end
    endtask

    initial begin
        int i0, t0;
        bit traf_done;
        traf_done = 0;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(cmd_valid == 0, "R1 no command in reset", cmd_valid, 0);
        chk(req_ready == 2'b11, "R1 ready in reset", req_ready, 3);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(cmd_valid == 0, "R1 no command after reset", cmd_valid, 0);
        chk(req_ready == 2'b11, "R1 ready after reset", req_ready, 3);

        // R2 contested bus: both pseudo-channels, activate then page hit
        wait_after_ref();
        i0 = n_log;
        fork
            begin send(0, 0, 0, 1, 5); send(0, 0, 0, 1, 6); end
            begin send(1, 0, 0, 1, 5); send(1, 0, 0, 1, 6); end
        join
        wait_log(i0 + 6);
        t0 = l_t[i0];
        expect_cmd(i0 + 0, t0, K_ACT, 0, 0, "R2 rr act pc0");
        expect_cmd(i0 + 1, t0, K_ACT, 1, 1, "R2 rr act pc1");
        expect_cmd(i0 + 2, t0, K_RD, 0, TRCD, "R2 rr first read pc0");
        expect_cmd(i0 + 3, t0, K_RD, 1, TRCD + 1, "R2 rr contested read pc1");
        expect_cmd(i0 + 4, t0, K_RD, 0, TRCD + 2, "R6 hit read pc0");
        expect_cmd(i0 + 5, t0, K_RD, 1, TRCD + 3, "R6 hit read pc1");

        // R6 row miss sequence on an idle bank, earliest legal cycles
        wait_after_ref();
        i0 = n_log;
        send(0, 0, 2, 10, 1);
        send(0, 1, 2, 11, 2);
        wait_log(i0 + 5);
        t0 = l_t[i0];
        expect_cmd(i0 + 0, t0, K_ACT, 0, 0, "R6 miss first act");
        expect_cmd(i0 + 1, t0, K_RD, 0, TRCD, "R3 read at trcd");
        expect_cmd(i0 + 2, t0, K_PRE, 0, TRAS, "R4 precharge at tras");
        expect_cmd(i0 + 3, t0, K_ACT, 0, TRAS + TRP, "R5 activate at trp");
        expect_cmd(i0 + 4, t0, K_WR, 0, TRAS + TRP + TRCD, "R6 write after reopen");
        chk(l_r[i0 + 3] == 11, "R6 reopened row", l_r[i0 + 3], 11);

        // R10 throttled page hits
        wait_after_ref();
        throttle = 1;
        i0 = n_log;
        for (int j = 0; j < 4; j++) send(1, 0, 1, 2, j);
        wait_log(i0 + 5);
        t0 = l_t[i0];
        expect_cmd(i0 + 0, t0, K_ACT, 1, 0, "R10 throttle act");
        for (int j = 0; j < 4; j++)
            expect_cmd(i0 + 1 + j, t0, K_RD, 1, TRCD + j * GAP, "R10 throttled read");
        throttle = 0;

        // R11 queue full
        wait_after_ref();
        send(0, 0, 3, 4, 9);
        send(0, 1, 3, 4, 10);
        @(negedge clk);
        chk(req_ready[0] == 0, "R11 ready low when full", req_ready[0], 0);
        send(0, 0, 3, 4, 11);
        while (q_h[0] != q_t[0]) @(negedge clk);
        chk(1, "R11 all requests served", q_h[0], q_t[0]);

        // random traffic with throttle toggling
        @(posedge clk); #1;
        fork
            begin
                fork
                    rand_traffic(0, 150, 17);
                    rand_traffic(1, 150, 91);
                join
                traf_done = 1;
            end
            begin
                while (!traf_done) begin
                    repeat (37) @(posedge clk);
                    #1 throttle = ~throttle;
                end
                throttle = 0;
            end
        join
        while (q_h[0] != q_t[0] || q_h[1] != q_t[1]) @(negedge clk);
        chk(q_h[0] == q_t[0] && q_h[1] == q_t[1], "R7 random traffic drained", q_h[0] + q_h[1], q_t[0] + q_t[1]);
        repeat (TREFI) @(negedge clk);
        chk(n_ref >= cyc / TREFI - 1 && n_ref <= cyc / TREFI, "R8 refresh count", n_ref, cyc / TREFI);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule